// File: doc/BRIEF.md
# Two-Wire Bus Fault Monitor

This block sits beside a two-wire (I2C) byte-transfer engine and watches the bus passively. The raw clock and data lines pass through a synchronizer, and the block compares each synchronized sample with the one before it. From that comparison, together with a few status signals from the engine, it finds four kinds of fault. The first is a data edge while the clock is high inside a byte, where a start or stop condition is not allowed. The second is a lost arbitration while the engine is sending a bit. The third is a missing acknowledge after a transmitted byte. The fourth is a clock held low for longer than a limit that can be programmed.

Each fault sets a sticky flag. A flag stays set until software writes a one to its bit of the clear strobe. When any flag is set and the interrupt enable is on, a combined interrupt line is raised. Each new fault also sends a one-cycle abort pulse to the engine. After a lost arbitration, a release output tells the engine to let go of both lines.

Top module: `i2c_fault_monitor`

## Requirements
- R1: After synchronous reset the flags, `irq`, `abort` and `release_lines` are all 0.
- R2: Flag bit 0 (bus fault) sets when SDA changes in either direction while SCL stays high and `byte_bit_active` is 1. The same edge with `byte_bit_active` at 0 sets no flag.
- R3: Flag bit 1 (arbitration) sets on a rising SCL edge when `tx_bit_en` is 1, `tx_bit` is 1 (the line is released) and SDA is sampled low. `release_lines` is 1 whenever this flag is set. Every other combination of these inputs leaves the flag at 0.
- R4: Flag bit 2 (no acknowledge) sets on a rising SCL edge when `ack_slot` is 1 and SDA is sampled high. SDA low in the ack slot, or SDA high outside the ack slot, sets nothing.
- R5: Flag bit 3 (stretch timeout) sets once the synchronized SCL has been low for `stretch_limit` consecutive cycles. The count restarts whenever SCL is high. A limit of 0 turns the check off. A single low period sets the flag only once.
- R6: Flags are sticky. A 1 in bit i of `clear_strobe` clears only flag i. A fault that arrives in the same cycle as the clear of its bit still sets the flag.
- R7: `irq` is 1 exactly when `irq_enable` is 1 and at least one flag is set.
- R8: `abort` is a one-cycle pulse for each new fault event. It stays 0 while flags remain set and no new fault occurs.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| scl_raw | input | 1 | Clock line as seen on the pad |
| sda_raw | input | 1 | Data line as seen on the pad |
| tx_bit_en | input | 1 | Engine is sending the current data bit |
| tx_bit | input | 1 | Value the engine puts on SDA (1 = released) |
| byte_bit_active | input | 1 | Engine is inside a byte's bit positions |
| ack_slot | input | 1 | Current bit is the ack slot after a transmitted byte |
| stretch_limit | input | STRETCH_W | Longest allowed SCL-low time in cycles (0 = off) |
| irq_enable | input | 1 | Interrupt enable |
| clear_strobe | input | 4 | Write-one-to-clear, one bit per flag |
| err_flags | output | 4 | Sticky flags: bus, arbitration, no-ack, timeout |
| irq | output | 1 | Combined interrupt |
| abort | output | 1 | One-cycle abort request to the engine |
| release_lines | output | 1 | Engine must release SCL and SDA |

## Verification
The assertions assume that `stretch_limit` does not change while SCL is low. Under that assumption the timeout counter never goes past the limit and fires only once in each low period. They also assume that the engine's qualifier inputs are steady across the synchronizer delay. The bench keeps to both assumptions. It changes the limit and the qualifiers only while the lines are idle. It then gives the synchronizer several cycles to settle before it makes the line transition under test, so every expected flag follows from the line pattern alone.

// File: rtl/twf_pkg.sv
package twf_pkg;
  localparam int NUM_FAULTS  = 4;
  localparam int IDX_BUS     = 0;
  localparam int IDX_ARB     = 1;
  localparam int IDX_NOACK   = 2;
  localparam int IDX_STRETCH = 3;
  typedef logic [NUM_FAULTS-1:0] fault_vec_t;
endpackage

// File: rtl/twf_sync.sv
module twf_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst,
  input  logic [WIDTH-1:0] d_in,
  output logic [WIDTH-1:0] d_out
);
  logic [WIDTH-1:0] chain [STAGES];

  generate
    for (genvar s = 0; s < STAGES; s++) begin : g_stage
      if (s == 0) begin : g_first
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= d_in;
        end
      end else begin : g_next
        always_ff @(posedge clk) begin
          if (rst) chain[s] <= '1;
          else     chain[s] <= chain[s-1];
        end
      end
    end
  endgenerate

  assign d_out = chain[STAGES-1];
endmodule

// File: rtl/twf_event_detect.sv
module twf_event_detect (
  input  logic clk,
  input  logic rst,
  input  logic scl_s,
  input  logic sda_s,
  input  logic byte_bit_active,
  input  logic ack_slot,
  input  logic tx_bit_en,
  input  logic tx_bit,
  output logic ev_bus,
  output logic ev_arb,
  output logic ev_noack
);
  logic scl_d, sda_d;
  logic scl_rise;

  always_ff @(posedge clk) begin
    if (rst) begin
      scl_d <= 1'b1;
      sda_d <= 1'b1;
    end else begin
      scl_d <= scl_s;
      sda_d <= sda_s;
    end
  end

  assign scl_rise = scl_s & ~scl_d;

  always_comb begin
    ev_bus   = scl_s & scl_d & (sda_s ^ sda_d) & byte_bit_active;
    ev_arb   = scl_rise & tx_bit_en & tx_bit & ~sda_s;
    ev_noack = scl_rise & ack_slot & sda_s;
  end

  // R4: no-ack and arbitration loss can only be reported on a clock rising edge
  p_edge_only_r4: assert property (@(posedge clk) disable iff (rst)
    (ev_noack || ev_arb) |-> (scl_s && !$past(scl_s)));
endmodule

// File: rtl/twf_stretch_timer.sv
module twf_stretch_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         scl_s,
  input  logic [W-1:0] limit,
  output logic         ev_timeout
);
  logic [W-1:0] cnt;
  logic         armed;

  assign armed = (limit != '0);

  always_ff @(posedge clk) begin
    if (rst || scl_s)
      cnt <= '0;
    else if (armed && cnt < limit)
      cnt <= cnt + W'(1);
  end

  assign ev_timeout = ~scl_s & armed & (cnt == limit - W'(1));

  // R5: a high clock restarts the low-time count
  p_count_restart_r5: assert property (@(posedge clk) disable iff (rst)
    scl_s |=> (cnt == '0));

  // R5: one low period fires the timeout only once (limit held steady)
  p_single_fire_r5: assert property (@(posedge clk) disable iff (rst)
    (ev_timeout && $stable(limit)) |=> !ev_timeout);
endmodule

// File: rtl/twf_flag_bank.sv
module twf_flag_bank
  import twf_pkg::*;
(
  input  logic       clk,
  input  logic       rst,
  input  fault_vec_t set_vec,
  input  fault_vec_t clr_vec,
  input  logic       irq_enable,
  output fault_vec_t flags,
  output logic       irq,
  output logic       abort,
  output logic       release_lines
);
  fault_vec_t flags_nxt;

  generate
    for (genvar i = 0; i < NUM_FAULTS; i++) begin : g_flag
      assign flags_nxt[i] = set_vec[i] | (flags[i] & ~clr_vec[i]);

      always_ff @(posedge clk) begin
        if (rst) flags[i] <= 1'b0;
        else     flags[i] <= flags_nxt[i];
      end

      // R6: a fault beats a clear arriving in the same cycle
      p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
        set_vec[i] |=> flags[i]);

      // R6: a clear with no new fault empties the flag
      p_clear_works_r6: assert property (@(posedge clk) disable iff (rst)
        (clr_vec[i] && !set_vec[i]) |=> !flags[i]);
    end
  endgenerate

  always_ff @(posedge clk) begin
    if (rst) begin
      irq           <= 1'b0;
      abort         <= 1'b0;
      release_lines <= 1'b0;
    end else begin
      irq           <= irq_enable & (|flags_nxt);
      abort         <= |set_vec;
      release_lines <= flags_nxt[IDX_ARB];
    end
  end

  // R7: the interrupt is never raised without a flag behind it
  p_irq_has_cause_r7: assert property (@(posedge clk) disable iff (rst)
    irq |-> (|flags));

  // R8: an abort always comes with a set flag
  p_abort_has_cause_r8: assert property (@(posedge clk) disable iff (rst)
    abort |-> (|flags));

  // R3: arbitration flag and line release go together
  p_release_r3: assert property (@(posedge clk) disable iff (rst)
    flags[IDX_ARB] |-> release_lines);
endmodule

// File: rtl/i2c_fault_monitor.sv
module i2c_fault_monitor
  import twf_pkg::*;
#(
  parameter int SYNC_STAGES = 2,
  parameter int STRETCH_W   = 8
) (
  input  logic                 clk,
  input  logic                 rst,
  input  logic                 scl_raw,
  input  logic                 sda_raw,
  input  logic                 tx_bit_en,
  input  logic                 tx_bit,
  input  logic                 byte_bit_active,
  input  logic                 ack_slot,
  input  logic [STRETCH_W-1:0] stretch_limit,
  input  logic                 irq_enable,
  input  logic [3:0]           clear_strobe,
  output logic [3:0]           err_flags,
  output logic                 irq,
  output logic                 abort,
  output logic                 release_lines
);
  logic [1:0] lines_s;
  logic       scl_s, sda_s;
  logic       ev_bus, ev_arb, ev_noack, ev_timeout;
  fault_vec_t set_vec;
  fault_vec_t flags;

  twf_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk   (clk),
    .rst   (rst),
    .d_in  ({scl_raw, sda_raw}),
    .d_out (lines_s)
  );

  assign scl_s = lines_s[1];
  assign sda_s = lines_s[0];

  twf_event_detect u_detect (
    .clk             (clk),
    .rst             (rst),
    .scl_s           (scl_s),
    .sda_s           (sda_s),
    .byte_bit_active (byte_bit_active),
    .ack_slot        (ack_slot),
    .tx_bit_en       (tx_bit_en),
    .tx_bit          (tx_bit),
    .ev_bus          (ev_bus),
    .ev_arb          (ev_arb),
    .ev_noack        (ev_noack)
  );

  twf_stretch_timer #(.W(STRETCH_W)) u_timer (
    .clk        (clk),
    .rst        (rst),
    .scl_s      (scl_s),
    .limit      (stretch_limit),
    .ev_timeout (ev_timeout)
  );

  always_comb begin
    set_vec              = '0;
    set_vec[IDX_BUS]     = ev_bus;
    set_vec[IDX_ARB]     = ev_arb;
    set_vec[IDX_NOACK]   = ev_noack;
    set_vec[IDX_STRETCH] = ev_timeout;
  end

  twf_flag_bank u_flags (
    .clk           (clk),
    .rst           (rst),
    .set_vec       (set_vec),
    .clr_vec       (clear_strobe),
    .irq_enable    (irq_enable),
    .flags         (flags),
    .irq           (irq),
    .abort         (abort),
    .release_lines (release_lines)
  );

  assign err_flags = flags;

  // R1: outputs are quiet in the cycle after reset
  p_reset_quiet_r1: assert property (@(posedge clk)
    $past(rst) |-> (err_flags == '0 && !irq && !abort && !release_lines));
endmodule

// File: tb/i2c_fault_monitor_test.sv
`timescale 1ns/1ps
module i2c_fault_monitor_test;
  logic       clk = 1'b0;
  logic       rst;
  logic       scl_raw, sda_raw, tx_bit_en, tx_bit, byte_bit_active, ack_slot;
  logic [7:0] stretch_limit;
  logic       irq_enable;
  logic [3:0] clear_strobe;
  logic [3:0] err_flags;
  logic       irq, abort, release_lines;

  int n_chk = 0;
  int n_bad = 0;
  int abort_cnt = 0;
  bit done = 0;

  always #2 clk = ~clk;

  i2c_fault_monitor #(.SYNC_STAGES(2), .STRETCH_W(8)) uut (
    .clk(clk), .rst(rst), .scl_raw(scl_raw), .sda_raw(sda_raw),
    .tx_bit_en(tx_bit_en), .tx_bit(tx_bit), .byte_bit_active(byte_bit_active),
    .ack_slot(ack_slot), .stretch_limit(stretch_limit), .irq_enable(irq_enable),
    .clear_strobe(clear_strobe), .err_flags(err_flags), .irq(irq),
    .abort(abort), .release_lines(release_lines)
  );

  always @(negedge clk) if (abort) abort_cnt++;

  task automatic tick(input int n = 1);
    repeat (n) begin
      @(posedge clk);
      #1;
    end
  endtask

  task automatic check(input string req, input int act, input int exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic clear_all();
    clear_strobe = 4'hF;
    tick();
    clear_strobe = 4'h0;
    tick();
  endtask

  task automatic summary();
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_bad++;
      $display("FAIL watchdog expired");
      summary();
    end
  end

  initial begin
    bit seen;
    rst = 1'b1; scl_raw = 1'b1; sda_raw = 1'b1; tx_bit_en = 1'b0; tx_bit = 1'b0;
    byte_bit_active = 1'b0; ack_slot = 1'b0; stretch_limit = 8'd0;
    irq_enable = 1'b0; clear_strobe = 4'h0;
    tick(3);
    rst = 1'b0;
    tick();
    check("R1 flags", int'(err_flags), 0);
    check("R1 irq", int'(irq), 0);
    check("R1 abort", int'(abort), 0);
    check("R1 release", int'(release_lines), 0);

    // R2 sweep: qualifier x edge direction
    for (int ba = 0; ba < 2; ba++) begin
      for (int dir = 0; dir < 2; dir++) begin
        scl_raw = 1'b1; sda_raw = dir[0]; byte_bit_active = 1'b0;
        tick(4);
        byte_bit_active = ba[0];
        tick();
        abort_cnt = 0;
        sda_raw = ~dir[0];
        tick(5);
        check("R2 bus flag", int'(err_flags), ba);
        check("R8 abort pulses", abort_cnt, ba);
        abort_cnt = 0;
        tick(3);
        check("R8 abort quiet while flag held", abort_cnt, 0);
        byte_bit_active = 1'b0;
        clear_all();
      end
    end

    // R3 sweep: enable x driven bit x sampled line
    for (int e = 0; e < 2; e++) begin
      for (int b = 0; b < 2; b++) begin
        for (int s = 0; s < 2; s++) begin
          int exp_arb;
          exp_arb = e & b & (1 - s);
          scl_raw = 1'b0; sda_raw = s[0]; tx_bit_en = e[0]; tx_bit = b[0];
          tick(4);
          scl_raw = 1'b1;
          tick(5);
          check("R3 arb flag", int'(err_flags), exp_arb << 1);
          check("R3 release lines", int'(release_lines), exp_arb);
          scl_raw = 1'b0; tx_bit_en = 1'b0;
          tick(3);
          clear_all();
        end
      end
    end

    // R4 sweep: ack slot x sampled line
    for (int a = 0; a < 2; a++) begin
      for (int s = 0; s < 2; s++) begin
        scl_raw = 1'b0; sda_raw = s[0]; ack_slot = a[0];
        tick(4);
        scl_raw = 1'b1;
        tick(5);
        check("R4 noack flag", int'(err_flags), (a & s) << 2);
        scl_raw = 1'b0; ack_slot = 1'b0;
        tick(3);
        clear_all();
      end
    end

    // R6/R7: build bus + noack flags, per-bit clear, irq gating
    scl_raw = 1'b0; sda_raw = 1'b1; ack_slot = 1'b1;
    tick(4);
    scl_raw = 1'b1;
    tick(4);
    ack_slot = 1'b0; byte_bit_active = 1'b1;
    tick();
    sda_raw = 1'b0;
    tick(4);
    byte_bit_active = 1'b0;
    check("R6 two flags held", int'(err_flags), 5);
    for (int ie = 0; ie < 2; ie++) begin
      irq_enable = ie[0];
      tick(2);
      check("R7 irq with flags", int'(irq), ie);
    end
    clear_strobe = 4'b0100;
    tick();
    clear_strobe = 4'h0;
    tick();
    check("R6 per-bit clear", int'(err_flags), 1);
    check("R7 irq with one flag", int'(irq), 1);
    clear_strobe = 4'b0001;
    tick();
    clear_strobe = 4'h0;
    tick();
    check("R6 all cleared", int'(err_flags), 0);
    check("R7 irq drops", int'(irq), 0);

    // R6: set wins over a clear held across the fault
    scl_raw = 1'b0; sda_raw = 1'b1; ack_slot = 1'b1;
    tick(4);
    clear_strobe = 4'b0100;
    scl_raw = 1'b1;
    seen = 0;
    for (int k = 0; k < 6; k++) begin
      tick();
      if (err_flags[2]) seen = 1;
    end
    clear_strobe = 4'h0; ack_slot = 1'b0;
    check("R6 set beats clear", int'(seen), 1);
    check("R6 cleared after", int'(err_flags), 0);
    check("R7 irq after clear", int'(irq), 0);
    irq_enable = 1'b0;
    tick(2);

    // R5 sweep: limit x low duration
    scl_raw = 1'b1; sda_raw = 1'b1;
    for (int lim = 1; lim <= 6; lim++) begin
      for (int d = 1; d <= lim + 2; d++) begin
        stretch_limit = 8'(lim);
        scl_raw = 1'b1;
        tick(4);
        abort_cnt = 0;
        scl_raw = 1'b0;
        tick(d);
        scl_raw = 1'b1;
        tick(6);
        check("R5 timeout flag", int'(err_flags), (d >= lim) ? 8 : 0);
        check("R8 timeout abort", abort_cnt, (d >= lim) ? 1 : 0);
        clear_all();
      end
    end

    // R5: long low period fires once
    stretch_limit = 8'd3;
    tick(4);
    abort_cnt = 0;
    scl_raw = 1'b0;
    tick(30);
    check("R5 long low flag", int'(err_flags), 8);
    check("R5 single fire", abort_cnt, 1);
    scl_raw = 1'b1;
    tick(4);
    clear_all();

    // R5: limit 0 disables
    stretch_limit = 8'd0;
    scl_raw = 1'b0;
    tick(40);
    check("R5 disabled", int'(err_flags), 0);
    scl_raw = 1'b1;
    tick(4);

    done = 1;
    summary();
  end
endmodule